// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps transitions on one asynchronous input pin. The pin passes through a two-stage synchronizer. An edge detector then compares the synchronised level with its value one cycle earlier. A 3-bit mode selects which transitions count: rising, falling, both, or only every 4th or every 16th rising transition. Each qualifying event copies the current count of one of two free-running 16-bit timers into a four-entry FIFO. The timers themselves sit outside the block and arrive as input ports.

Software reads stamps through a single read port. The port always shows the oldest entry, and a read strobe pops it. A not-empty flag and a sticky overflow flag report the buffer state. A one-cycle interrupt pulse is raised after a programmable number of stored captures: 1, 2, 3 or 4.

Configuration is written as a whole with one strobe: mode, timer select and interrupt threshold. Each write restarts the prescaler and the interrupt counter. A write that selects the off mode also empties the FIFO and clears the overflow flag.

Top module: `icap_unit`

## Requirements
- R1: A pin transition that is stable before clock edge k is stored at edge k+2. The stored value is the timer count presented at that edge, so not-empty first reads 1 after edge k+2 and is still 0 after edge k+1.
- R2: Simple mode codes: 3'b011 stores on every rising transition, 3'b010 on every falling transition, and 3'b001 on every transition of either polarity.
- R3: Prescaled mode codes: 3'b100 stores on every 4th rising transition and 3'b101 on every 16th rising transition. Falling transitions are ignored in these modes, and counting starts from the last configuration write.
- R4: Timer select 0 stores timer A and timer select 1 stores timer B.
- R5: The FIFO holds four entries in arrival order. The read data output shows the oldest entry, and a read strobe pops it. A read strobe while the FIFO is empty has no effect.
- R6: The not-empty status is 1 exactly when at least one entry is held. It is 0 after reset.
- R7: A capture that arrives while the FIFO is full and no read is strobed is discarded and sets the overflow flag. The flag stays set until the next configuration write that selects the off mode.
- R8: A capture and a read in the same cycle on a full FIFO are both performed. The capture is stored and the overflow flag stays clear.
- R9: With threshold field n, a one-cycle interrupt pulse follows the (n+1)-th stored capture counted since the last interrupt or configuration write. Discarded captures do not count.
- R10: A configuration write restarts the prescaler and the interrupt counter. An event that occurs in the same cycle as the write is not stored.
- R11: Mode code 3'b000 (off) and the reserved codes 3'b110 and 3'b111 store nothing. Writing the off code empties the FIFO and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous capture pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Capture mode code |
| cfg_tsel_i | input | 1 | Timer select (0 = A, 1 = B) |
| cfg_irqn_i | input | 2 | Interrupt threshold n (fires after n+1 captures) |
| tmr_a_i | input | 16 | Timer A count |
| tmr_b_i | input | 16 | Timer B count |
| rd_i | input | 1 | Pop strobe for the oldest entry |
| rd_data_o | output | 16 | Oldest stored timestamp |
| not_empty_o | output | 1 | FIFO holds at least one entry |
| ovf_o | output | 1 | Sticky capture overflow |
| irq_o | output | 1 | Capture interrupt pulse |

## Verification
A table of pulse trains is run through every mode code, and the number of stored stamps is counted for each one. The results separate rising, falling and both-edge detection. They also confirm divide-by-4 against divide-by-16 and show that the reserved codes stay silent. A train of 15 pulses under divide-by-16 checks that the prescaler does not fire one edge early. Directed runs then pin the two-edge latency and the timer choice against a known counter value. They also cover ordering through a full FIFO, a discarded fifth stamp versus a pop in the same cycle, and a prescaler and interrupt counter cut short by a configuration write.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [2:0] {
    MODE_OFF   = 3'b000,
    MODE_BOTH  = 3'b001,
    MODE_FALL  = 3'b010,
    MODE_RISE  = 3'b011,
    MODE_DIV4  = 3'b100,
    MODE_DIV16 = 3'b101,
    MODE_RSV6  = 3'b110,
    MODE_RSV7  = 3'b111
  } cap_mode_e;
endpackage

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  cap_mode_e mode_i,
  input  logic      clr_i,
  output logic      evt_o
);
  localparam int PS_W = $clog2(DIV_HI);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [PS_W-1:0]        ps_q, ps_lim;
  logic                   lvl, rise, fall, ps_mode, ps_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl     = sync_q[SYNC_STAGES-1];
  assign rise    = lvl & ~prev_q;
  assign fall    = ~lvl & prev_q;
  assign ps_mode = (mode_i == MODE_DIV4) || (mode_i == MODE_DIV16);
  assign ps_lim  = (mode_i == MODE_DIV4) ? PS_W'(DIV_LO - 1) : PS_W'(DIV_HI - 1);
  assign ps_hit  = rise && (ps_q == ps_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ps_q <= '0;
    else if (clr_i)            ps_q <= '0;
    else if (ps_mode && rise)  ps_q <= ps_hit ? '0 : ps_q + 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      MODE_BOTH:              evt_o = rise | fall;
      MODE_FALL:              evt_o = fall;
      MODE_RISE:              evt_o = rise;
      MODE_DIV4, MODE_DIV16:  evt_o = ps_hit;
      default:                evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic          push_ok_o,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  assign pop_ok    = pop_i && (cnt_q != '0);
  assign push_ok_o = push_i && ((cnt_q != CW'(DEPTH)) || pop_ok);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok_o) wr_q <= nxt(wr_q);
      if (pop_ok)    rd_q <= nxt(rd_q);
      if (push_ok_o && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (!push_ok_o && pop_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (!clr_i && push_ok_o && wr_q == PW'(g)) mem_q[g] <= data_i;
    end
  end

  assign head_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/icap_irq.sv
module icap_irq #(
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [TW-1:0] thr_i,
  output logic          irq_o
);
  logic [TW-1:0] cnt_q;
  logic          hit;

  assign hit = inc_i && (cnt_q == thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= hit && !clr_i;
      if (clr_i)      cnt_q <= '0;
      else if (hit)   cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int TW    = 16,
  parameter int DEPTH = 4,
  parameter int IRQ_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_tsel_i,
  input  logic [IRQ_W-1:0] cfg_irqn_i,
  input  logic [TW-1:0]    tmr_a_i,
  input  logic [TW-1:0]    tmr_b_i,
  input  logic             rd_i,
  output logic [TW-1:0]    rd_data_o,
  output logic             not_empty_o,
  output logic             ovf_o,
  output logic             irq_o
);
  cap_mode_e        mode_q;
  logic             tsel_q;
  logic [IRQ_W-1:0] irqn_q;
  logic             evt, cap, push_ok, off_clr;
  logic [TW-1:0]    stamp;
  logic [CNT_W-1:0] fifo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      tsel_q <= 1'b0;
      irqn_q <= '0;
    end else if (cfg_we_i) begin
      mode_q <= cap_mode_e'(cfg_mode_i);
      tsel_q <= cfg_tsel_i;
      irqn_q <= cfg_irqn_i;
    end
  end

  icap_edge #(.SYNC_STAGES(2), .DIV_LO(4), .DIV_HI(16)) i_edge (
    .clk_i, .rst_ni, .pin_i,
    .mode_i (mode_q),
    .clr_i  (cfg_we_i),
    .evt_o  (evt)
  );

  // capture is dropped in the cycle of a configuration write
  assign cap     = evt && !cfg_we_i;
  assign stamp   = tsel_q ? tmr_b_i : tmr_a_i;
  assign off_clr = cfg_we_i && (cfg_mode_i == MODE_OFF);

  icap_fifo #(.W(TW), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .clr_i     (off_clr),
    .push_i    (cap),
    .data_i    (stamp),
    .pop_i     (rd_i),
    .push_ok_o (push_ok),
    .head_o    (rd_data_o),
    .cnt_o     (fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_o <= 1'b0;
    else if (off_clr)         ovf_o <= 1'b0;
    else if (cap && !push_ok) ovf_o <= 1'b1;
  end

  assign not_empty_o = (fifo_cnt != '0);

  icap_irq #(.TW(IRQ_W)) i_irq (
    .clk_i, .rst_ni,
    .clr_i (cfg_we_i),
    .inc_i (push_ok),
    .thr_i (irqn_q),
    .irq_o
  );
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int TW    = 16,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             rd_i,
  input logic [2:0]       mode_q,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic [TW-1:0]    rd_data_o,
  input logic             not_empty_o,
  input logic             ovf_o,
  input logic             irq_o
);
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !cfg_we_i |=> ovf_o);

  assert_ovf_only_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(fifo_cnt) == CNT_W'(DEPTH));

  assert_head_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_empty_o && !rd_i && !cfg_we_i |=> not_empty_o && $stable(rd_data_o));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_empty_by_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(not_empty_o) |-> $past(rd_i || cfg_we_i));

  assert_off_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == 3'b000 |-> !not_empty_o && !ovf_o);

  assert_irq_has_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> not_empty_o);
endmodule

bind icap_unit icap_unit_chk #(.TW(TW), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .rd_i        (rd_i),
  .mode_q      (mode_q),
  .fifo_cnt    (fifo_cnt),
  .rd_data_o   (rd_data_o),
  .not_empty_o (not_empty_o),
  .ovf_o       (ovf_o),
  .irq_o       (irq_o)
);

// File: tb/test_icap_unit.sv
`timescale 1ns/1ps
module test_icap_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_mode_i = 3'b000;
  logic        cfg_tsel_i = 1'b0;
  logic [1:0]  cfg_irqn_i = 2'd0;
  logic [15:0] tmr_a_i = 16'd0;
  logic [15:0] tmr_b_i = 16'h8000;
  logic        rd_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        not_empty_o, ovf_o, irq_o;

  int total = 0, bad = 0, irq_seen = 0;
  bit done = 1'b0;
  logic [15:0] sa, sb;
  logic [15:0] vals [6];

  always #4 clk_i = ~clk_i;

  icap_unit i_icap_unit (.*);

  always @(negedge clk_i) begin
    tmr_a_i <= tmr_a_i + 16'd1;
    tmr_b_i <= tmr_b_i + 16'd3;
    if (irq_o) irq_seen <= irq_seen + 1;
  end

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] m, input logic s, input logic [1:0] n);
    cfg_we_i = 1'b1; cfg_mode_i = m; cfg_tsel_i = s; cfg_irqn_i = n;
    tick();
    cfg_we_i = 1'b0;
  endtask

  // set pin, note the timer values seen by the storing edge
  task automatic pin_set(input logic v);
    pin_i = v;
    tick(); tick();
    sa = tmr_a_i; sb = tmr_b_i;
    tick();
  endtask

  task automatic pop();
    rd_i = 1'b1; tick(); rd_i = 1'b0;
  endtask

  task automatic drain(output int n);
    n = 0;
    for (int i = 0; i < 8 && not_empty_o; i++) begin pop(); n++; end
  endtask

  // mode, pulses, expected stored count
  localparam logic [10:0] VEC [8] = '{
    {3'b011, 5'd3,  3'd3},
    {3'b010, 5'd3,  3'd3},
    {3'b001, 5'd2,  3'd4},
    {3'b100, 5'd8,  3'd2},
    {3'b100, 5'd3,  3'd0},
    {3'b101, 5'd16, 3'd1},
    {3'b101, 5'd15, 3'd0},
    {3'b110, 5'd3,  3'd0}
  };

  initial begin
    int n;
    #20; @(negedge clk_i); #1;
    rst_ni = 1'b1;
    tick();
    chk(!not_empty_o && !ovf_o && !irq_o, "R6 reset", {not_empty_o, ovf_o, irq_o}, 0);

    // R2 R3 R11 table
    foreach (VEC[v]) begin
      cfg(3'b000, 1'b0, 2'd3);
      cfg(VEC[v][10:8], 1'b0, 2'd3);
      for (int p = 0; p < int'(VEC[v][7:3]); p++) begin pin_set(1'b1); pin_set(1'b0); end
      drain(n);
      chk(n == int'(VEC[v][2:0]), $sformatf("R2/R3/R11 vec%0d", v), n, VEC[v][2:0]);
    end

    // R1 latency and R4 timer A
    cfg(3'b000, 1'b0, 2'd3); cfg(3'b011, 1'b0, 2'd3);
    pin_i = 1'b1; tick(); tick();
    chk(!not_empty_o, "R1 early", not_empty_o, 0);
    sa = tmr_a_i; tick();
    chk(not_empty_o, "R1 stored", not_empty_o, 1);
    chk(rd_data_o == sa, "R1 R4 timer A", rd_data_o, sa);
    pop(); pin_set(1'b0);

    // R4 timer B
    cfg(3'b011, 1'b1, 2'd3);
    pin_set(1'b1);
    chk(rd_data_o == sb, "R4 timer B", rd_data_o, sb);
    pop(); pin_set(1'b0);

    // R5 pop on empty ignored
    pop();
    chk(!not_empty_o, "R5 empty pop", not_empty_o, 0);

    // R5 R7 order and overflow
    cfg(3'b011, 1'b0, 2'd3);
    for (int i = 0; i < 5; i++) begin pin_set(1'b1); vals[i] = sa; pin_set(1'b0); end
    chk(ovf_o, "R7 overflow set", ovf_o, 1);
    for (int i = 0; i < 4; i++) begin
      chk(rd_data_o == vals[i], "R5 order", rd_data_o, vals[i]);
      pop();
    end
    chk(!not_empty_o, "R7 fifth discarded", not_empty_o, 0);
    cfg(3'b011, 1'b0, 2'd3);
    chk(ovf_o, "R7 sticky over nonoff write", ovf_o, 1);
    cfg(3'b000, 1'b0, 2'd3);
    chk(!ovf_o, "R11 off clears ovf", ovf_o, 0);

    // R11 off write empties FIFO
    cfg(3'b011, 1'b0, 2'd3);
    pin_set(1'b1); pin_set(1'b0);
    cfg(3'b000, 1'b0, 2'd3);
    chk(!not_empty_o, "R11 off empties", not_empty_o, 0);

    // R8 simultaneous pop and push on full
    cfg(3'b011, 1'b0, 2'd3);
    for (int i = 0; i < 4; i++) begin pin_set(1'b1); vals[i] = sa; pin_set(1'b0); end
    pin_i = 1'b1; tick(); tick();
    vals[4] = tmr_a_i;
    rd_i = 1'b1; tick(); rd_i = 1'b0;
    chk(!ovf_o, "R8 no overflow", ovf_o, 0);
    pin_set(1'b0);
    for (int i = 1; i < 5; i++) begin
      chk(rd_data_o == vals[i], "R8 order", rd_data_o, vals[i]);
      pop();
    end

    // R9 interrupt after 3 captures, repeated
    cfg(3'b011, 1'b0, 2'd2);
    irq_seen = 0;
    for (int i = 0; i < 6; i++) begin
      pin_set(1'b1); pop(); pin_set(1'b0);
      if (i == 2) chk(irq_seen == 1, "R9 first irq", irq_seen, 1);
    end
    chk(irq_seen == 2, "R9 irq count", irq_seen, 2);
    cfg(3'b011, 1'b0, 2'd0);
    irq_seen = 0;
    for (int i = 0; i < 3; i++) begin pin_set(1'b1); pop(); pin_set(1'b0); end
    chk(irq_seen == 3, "R9 every capture", irq_seen, 3);

    // R10 interrupt counter restarted by a write
    cfg(3'b011, 1'b0, 2'd1);
    irq_seen = 0;
    pin_set(1'b1); pop(); pin_set(1'b0);
    cfg(3'b011, 1'b0, 2'd1);
    pin_set(1'b1); pop(); pin_set(1'b0);
    chk(irq_seen == 0, "R10 irq count restarted", irq_seen, 0);
    pin_set(1'b1); pop(); pin_set(1'b0);
    chk(irq_seen == 1, "R10 irq after restart", irq_seen, 1);

    // R10 prescaler restarted by a write
    cfg(3'b100, 1'b0, 2'd3);
    for (int i = 0; i < 2; i++) begin pin_set(1'b1); pin_set(1'b0); end
    cfg(3'b100, 1'b0, 2'd3);
    for (int i = 0; i < 3; i++) begin pin_set(1'b1); pin_set(1'b0); end
    chk(!not_empty_o, "R10 prescaler restarted", not_empty_o, 0);
    pin_set(1'b1); pin_set(1'b0);
    chk(not_empty_o, "R10 fourth after restart", not_empty_o, 1);
    drain(n);

    // R10 event in write cycle not stored
    cfg(3'b011, 1'b0, 2'd3);
    pin_i = 1'b1; tick(); tick();
    cfg_we_i = 1'b1; cfg_mode_i = 3'b011; tick(); cfg_we_i = 1'b0;
    tick(); tick();
    chk(!not_empty_o, "R10 write-cycle event dropped", not_empty_o, 0);
    pin_set(1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule